// File: doc/BRIEF.md
# Set/Clear Register GPIO Controller

This block is a 32-pin general-purpose I/O controller placed behind a plain memory-mapped read/write strobe bus with 32-bit data. It drives output values and output enables to the pads. It samples the pad inputs through a two-flop synchroniser. It can raise a single combined interrupt from per-pin edge or level events.

Every per-pin configuration field is changed through a pair of write-only addresses. A write to the "set" address turns on the bits that are 1 in the data word. A write to the "clear" address turns those bits off. Bits written as 0 keep their value. Software never needs a read-modify-write, so several agents can update different pins at the same time without a lock.

A per-pin dual-edge bit makes that pin detect both edge directions, whatever its edge-type and polarity bits say. A per-pin debounce bit inserts a fixed-length stability filter between the synchroniser and the event logic.

Top module: `gpio_setclr_ctrl`

## Requirements
- R1: After reset every state register is zero. All pins are inputs (`pin_oe` = 0), `pin_out` = 0, interrupts are disabled and unmasked, the combined gate is off and `irq_out` = 0. Reads of 0x18, 0x70, 0xA0 and 0xB8 return 0.
- R2: Output data is written at 0x00 (set) and 0x04 (clear). Direction is written at 0x10 (set) and 0x14 (clear), with 1 meaning output. `pin_out` and `pin_oe` show the stored bits after the write edge. Bits written as 0 are unchanged. Address 0x18 reads back the direction bits.
- R3: Reads are registered: `bus_rdata` holds the value for `bus_addr` one clock after the edge that samples `bus_rd`. All set, clear and end-of-interrupt addresses (0x00, 0x04, 0x10, 0x14, 0x20, 0x24, 0x30, 0x34, 0x40, 0x44, 0x50, 0x54, 0x60, 0x64, 0x78, 0xB0, 0xB4) read as zero.
- R4: Address 0x80 returns the pin inputs after a two-flop synchroniser. A read sampled at the first edge after a pin change still returns the old value. A read sampled at the third edge returns the new value.
- R5: With edge-type bit 1 (set 0x40 / clear 0x44) a pin latches a pending event on a rising edge when its polarity bit (set 0x50 / clear 0x54) is 1, or on a falling edge when it is 0. With no debounce, `irq_out` rises at the third clock edge after the pin change.
- R6: A pin whose dual-edge bit is 1 (set 0xB0, clear 0xB4, status 0xB8) latches on both rising and falling edges, whatever its edge-type and polarity bits are. Once the dual-edge bit is cleared, the edge-type and polarity bits apply again.
- R7: With edge-type bit 0 the pin is level-sensitive. Its status bit is 1 while the synchronised level equals its polarity bit. The status bit is not latched, and writes to 0x78 have no effect on it.
- R8: Writing 1 to bit n of 0x78 clears pin n's latched edge event. Other pending pins are left as they were.
- R9: An edge on a pin whose enable bit (set 0x20 / clear 0x24) is 0 is discarded. Clearing a pin's enable bit also discards any event already latched on it.
- R10: Status at 0x70 is, per pin, the pending-or-active condition ANDed with enable and NOT mask (mask set 0x30 / clear 0x34). While a pin is masked its latched event is kept, and it shows again when the pin is unmasked.
- R11: Bit 0 of 0xA0 (written directly, readable) gates `irq_out`. `irq_out` equals that bit ANDed with the OR of all status bits.
- R12: With a pin's debounce bit set (set 0x60 / clear 0x64), a new synchronised value is accepted only after it has been seen on 4 consecutive clocks. A 3-clock pulse is rejected. A held rising edge raises `irq_out` at the seventh clock edge after the pin change.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock for all state |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_wr | input | 1 | Write strobe, one word per clock |
| bus_rd | input | 1 | Read strobe; data returned the next clock |
| bus_addr | input | 8 | Byte address of the register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Registered read data |
| pin_in | input | 32 | Asynchronous pad inputs |
| pin_out | output | 32 | Output data to pads |
| pin_oe | output | 32 | Output enable per pin (1 = drive) |
| irq_out | output | 1 | Combined interrupt request |

## Verification
Each result has a fixed due cycle.
- Configuration writes act on `pin_out`, `pin_oe`, status and `irq_out` at the edge that samples the write. Read data follows one edge after the read strobe.
- A level-type pin's status follows a pad change at the second edge. A latched edge event appears at the third edge, or at the seventh with debounce.

The bench pushes each expected read word into a scoreboard queue as it issues the read. A monitor pops and compares it at the falling edge after the sampling edge. Checks on `irq_out` are taken at a counted falling edge, just before and just after the edge where the event must appear, so an off-by-one latency is caught.

// File: rtl/gpio_sc_pkg.sv
// Package: shared register offsets and widths for the set/clear GPIO block.
// Assumes byte addressing with 8-bit addresses and 32-bit data words.
package gpio_sc_pkg;

    localparam int BUS_AW = 8;
    localparam int BUS_DW = 32;

    // write-one-to-set / write-one-to-clear pairs
    localparam logic [BUS_AW-1:0] A_DOUT_SET  = 8'h00;
    localparam logic [BUS_AW-1:0] A_DOUT_CLR  = 8'h04;
    localparam logic [BUS_AW-1:0] A_DIR_SET   = 8'h10;
    localparam logic [BUS_AW-1:0] A_DIR_CLR   = 8'h14;
    localparam logic [BUS_AW-1:0] A_IEN_SET   = 8'h20;
    localparam logic [BUS_AW-1:0] A_IEN_CLR   = 8'h24;
    localparam logic [BUS_AW-1:0] A_MSK_SET   = 8'h30;
    localparam logic [BUS_AW-1:0] A_MSK_CLR   = 8'h34;
    localparam logic [BUS_AW-1:0] A_ETYP_SET  = 8'h40;
    localparam logic [BUS_AW-1:0] A_ETYP_CLR  = 8'h44;
    localparam logic [BUS_AW-1:0] A_POL_SET   = 8'h50;
    localparam logic [BUS_AW-1:0] A_POL_CLR   = 8'h54;
    localparam logic [BUS_AW-1:0] A_DEB_SET   = 8'h60;
    localparam logic [BUS_AW-1:0] A_DEB_CLR   = 8'h64;
    localparam logic [BUS_AW-1:0] A_DUAL_SET  = 8'hB0;
    localparam logic [BUS_AW-1:0] A_DUAL_CLR  = 8'hB4;

    // readable and command addresses
    localparam logic [BUS_AW-1:0] A_DIR_RD    = 8'h18;
    localparam logic [BUS_AW-1:0] A_STATUS    = 8'h70;
    localparam logic [BUS_AW-1:0] A_EOI       = 8'h78;
    localparam logic [BUS_AW-1:0] A_PINS      = 8'h80;
    localparam logic [BUS_AW-1:0] A_COMB      = 8'hA0;
    localparam logic [BUS_AW-1:0] A_DUAL_RD   = 8'hB8;

    // Per-pin configuration gathered for the event logic
    typedef enum logic [1:0] {
        DET_LEVEL = 2'b00,
        DET_ONE   = 2'b01,
        DET_BOTH  = 2'b10
    } det_mode_e;

endpackage

// File: rtl/gpio_sc_w1sc.sv
// Module: one configuration field reached through a set address and a
// clear address. A 1 in the written word sets (or clears) the bit; a 0
// leaves it. Assumes set and clear offsets differ.
module gpio_sc_w1sc
    import gpio_sc_pkg::*;
#(
    parameter int                W       = 32,
    parameter logic [BUS_AW-1:0] SET_OFF = 8'h00,
    parameter logic [BUS_AW-1:0] CLR_OFF = 8'h04
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr,
    input  logic [BUS_AW-1:0] addr,
    input  logic [W-1:0]      wbits,
    output logic [W-1:0]      q
);

    logic set_hit;
    logic clr_hit;

    // decode the two addresses of this field
    always_comb begin
        set_hit = wr && (addr == SET_OFF);
        clr_hit = wr && (addr == CLR_OFF);
    end

    // apply set or clear mask to the stored bits
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            q <= '0;
        end else if (set_hit) begin
            q <= q | wbits;
        end else if (clr_hit) begin
            q <= q & ~wbits;
        end
    end

endmodule

// File: rtl/gpio_sc_regs.sv
// Module: register file of the GPIO block. It holds the eight set/clear
// fields and the combined-interrupt gate. It produces end-of-interrupt and
// enable-clear pulses, and returns registered read data.
// Assumes NPINS <= 32.
module gpio_sc_regs
    import gpio_sc_pkg::*;
#(
    parameter int NPINS = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr,
    input  logic              rd,
    input  logic [BUS_AW-1:0] addr,
    input  logic [BUS_DW-1:0] wdata,
    input  logic [NPINS-1:0]  pins_sync,
    input  logic [NPINS-1:0]  status,
    output logic [NPINS-1:0]  dout,
    output logic [NPINS-1:0]  dir,
    output logic [NPINS-1:0]  ien,
    output logic [NPINS-1:0]  imask,
    output logic [NPINS-1:0]  etype,
    output logic [NPINS-1:0]  pol,
    output logic [NPINS-1:0]  deb,
    output logic [NPINS-1:0]  dual,
    output logic              comb_en,
    output logic [NPINS-1:0]  eoi_pulse,
    output logic [NPINS-1:0]  ien_clr_pulse,
    output logic [BUS_DW-1:0] rdata
);

    localparam int NFIELD = 8;

    typedef logic [BUS_AW-1:0] off_t;
    localparam off_t SET_TAB [NFIELD] = '{A_DOUT_SET, A_DIR_SET, A_IEN_SET,
        A_MSK_SET, A_ETYP_SET, A_POL_SET, A_DEB_SET, A_DUAL_SET};
    localparam off_t CLR_TAB [NFIELD] = '{A_DOUT_CLR, A_DIR_CLR, A_IEN_CLR,
        A_MSK_CLR, A_ETYP_CLR, A_POL_CLR, A_DEB_CLR, A_DUAL_CLR};

    logic [NPINS-1:0] wbits;
    logic [NPINS-1:0] fld [NFIELD];
    logic [BUS_DW-1:0] rd_next;

    assign wbits = wdata[NPINS-1:0];

    // one set/clear slice per configuration field
    for (genvar f = 0; f < NFIELD; f++) begin : g_fld
        gpio_sc_w1sc #(
            .W       (NPINS),
            .SET_OFF (SET_TAB[f]),
            .CLR_OFF (CLR_TAB[f])
        ) u_fld (
            .clk   (clk),
            .rst_n (rst_n),
            .wr    (wr),
            .addr  (addr),
            .wbits (wbits),
            .q     (fld[f])
        );
    end

    assign dout  = fld[0];
    assign dir   = fld[1];
    assign ien   = fld[2];
    assign imask = fld[3];
    assign etype = fld[4];
    assign pol   = fld[5];
    assign deb   = fld[6];
    assign dual  = fld[7];

    // command pulses for the event logic, valid in the write cycle
    always_comb begin
        eoi_pulse     = (wr && addr == A_EOI)     ? wbits : '0;
        ien_clr_pulse = (wr && addr == A_IEN_CLR) ? wbits : '0;
    end

    // combined interrupt gate, a plain read/write bit
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            comb_en <= 1'b0;
        end else if (wr && addr == A_COMB) begin
            comb_en <= wdata[0];
        end
    end

    // select the readable word; write-only addresses give zero
    always_comb begin
        rd_next = '0;
        case (addr)
            A_DIR_RD:  rd_next[NPINS-1:0] = dir;
            A_STATUS:  rd_next[NPINS-1:0] = status;
            A_PINS:    rd_next[NPINS-1:0] = pins_sync;
            A_DUAL_RD: rd_next[NPINS-1:0] = dual;
            A_COMB:    rd_next[0]         = comb_en;
            default:   rd_next            = '0;
        endcase
    end

    // register the read word on the read strobe
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rdata <= '0;
        end else if (rd) begin
            rdata <= rd_next;
        end
    end

endmodule

// File: rtl/gpio_sc_infilter.sv
// Module: per-pin input path. A synchroniser chain feeds an optional
// stability filter. With the filter enabled, a new value is taken only after
// DEB_LEN consecutive equal samples. With it disabled, the filter register
// tracks the synchronised value, so switching the filter causes no glitch.
// Assumes SYNC_STAGES >= 2 and DEB_LEN >= 2.
module gpio_sc_infilter #(
    parameter int NPINS       = 32,
    parameter int SYNC_STAGES = 2,
    parameter int DEB_LEN     = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [NPINS-1:0] pin_in,
    input  logic [NPINS-1:0] deb_en,
    output logic [NPINS-1:0] pins_sync,
    output logic [NPINS-1:0] pins_clean
);

    localparam int CNT_W = (DEB_LEN > 2) ? $clog2(DEB_LEN) : 1;
    localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(DEB_LEN - 1);

    for (genvar i = 0; i < NPINS; i++) begin : g_pin
        logic [SYNC_STAGES-1:0] chain;
        logic                   held;
        logic [CNT_W-1:0]       cnt;
        logic                   s;

        assign s = chain[SYNC_STAGES-1];

        // shift the pad value through the synchroniser
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                chain <= '0;
            end else begin
                chain <= {chain[SYNC_STAGES-2:0], pin_in[i]};
            end
        end

        // count consecutive differing samples and accept at the limit
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                held <= 1'b0;
                cnt  <= '0;
            end else if (!deb_en[i] || (s == held)) begin
                held <= s;
                cnt  <= '0;
            end else if (cnt == CNT_LAST) begin
                held <= s;
                cnt  <= '0;
            end else begin
                cnt <= cnt + 1'b1;
            end
        end

        assign pins_sync[i]  = s;
        assign pins_clean[i] = deb_en[i] ? held : s;
    end

endmodule

// File: rtl/gpio_sc_irqlogic.sv
// Module: per-pin event detection, the pending latch and the combined
// interrupt. Edge-mode pins latch events; level-mode pins report their live
// level. Dual-edge overrides type and polarity. Assumes clean inputs are
// already synchronous to clk.
module gpio_sc_irqlogic
    import gpio_sc_pkg::*;
#(
    parameter int NPINS = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [NPINS-1:0] clean,
    input  logic [NPINS-1:0] ien,
    input  logic [NPINS-1:0] imask,
    input  logic [NPINS-1:0] etype,
    input  logic [NPINS-1:0] pol,
    input  logic [NPINS-1:0] dual,
    input  logic             comb_en,
    input  logic [NPINS-1:0] eoi_pulse,
    input  logic [NPINS-1:0] ien_clr_pulse,
    output logic [NPINS-1:0] pend,
    output logic [NPINS-1:0] status,
    output logic             irq
);

    logic [NPINS-1:0] prev;
    logic [NPINS-1:0] hit;
    logic [NPINS-1:0] edge_mode;
    logic [NPINS-1:0] raw;

    // remember last clean level for edge detection
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            prev <= '0;
        end else begin
            prev <= clean;
        end
    end

    // per-pin detector selection
    for (genvar i = 0; i < NPINS; i++) begin : g_det
        det_mode_e mode;
        logic      rise;
        logic      fall;

        assign rise = clean[i] & ~prev[i];
        assign fall = ~clean[i] & prev[i];

        // pick detector kind: dual-edge first, then edge type
        always_comb begin
            if (dual[i]) begin
                mode = DET_BOTH;
            end else if (etype[i]) begin
                mode = DET_ONE;
            end else begin
                mode = DET_LEVEL;
            end
        end

        // event and reported condition for this pin
        always_comb begin
            case (mode)
                DET_BOTH: begin
                    hit[i]       = rise | fall;
                    edge_mode[i] = 1'b1;
                    raw[i]       = pend[i];
                end
                DET_ONE: begin
                    hit[i]       = pol[i] ? rise : fall;
                    edge_mode[i] = 1'b1;
                    raw[i]       = pend[i];
                end
                default: begin
                    hit[i]       = 1'b0;
                    edge_mode[i] = 1'b0;
                    raw[i]       = ~(clean[i] ^ pol[i]);
                end
            endcase
        end
    end

    // latch enabled edge events; new events win over end-of-interrupt
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pend <= '0;
        end else begin
            pend <= ((pend & ~(eoi_pulse & edge_mode)) | (hit & ien))
                    & ~ien_clr_pulse;
        end
    end

    // reportable status and the gated combined line
    always_comb begin
        status = raw & ien & ~imask;
        irq    = comb_en & (|status);
    end

endmodule

// File: rtl/gpio_setclr_ctrl.sv
// Module: top of the set/clear GPIO controller. It joins the register file,
// the input filter and the event logic. Bus: single-cycle write strobe;
// read strobe with data one clock later. Assumes NPINS <= 32.
module gpio_setclr_ctrl
    import gpio_sc_pkg::*;
#(
    parameter int NPINS       = 32,
    parameter int SYNC_STAGES = 2,
    parameter int DEB_LEN     = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_wr,
    input  logic              bus_rd,
    input  logic [BUS_AW-1:0] bus_addr,
    input  logic [BUS_DW-1:0] bus_wdata,
    output logic [BUS_DW-1:0] bus_rdata,
    input  logic [NPINS-1:0]  pin_in,
    output logic [NPINS-1:0]  pin_out,
    output logic [NPINS-1:0]  pin_oe,
    output logic              irq_out
);

    logic [NPINS-1:0] dout;
    logic [NPINS-1:0] dir;
    logic [NPINS-1:0] ien;
    logic [NPINS-1:0] imask;
    logic [NPINS-1:0] etype;
    logic [NPINS-1:0] pol;
    logic [NPINS-1:0] deb;
    logic [NPINS-1:0] dual;
    logic             comb_en;
    logic [NPINS-1:0] eoi_pulse;
    logic [NPINS-1:0] ien_clr_pulse;
    logic [NPINS-1:0] pins_sync;
    logic [NPINS-1:0] pins_clean;
    logic [NPINS-1:0] pend;
    logic [NPINS-1:0] status;

    gpio_sc_regs #(.NPINS(NPINS)) u_regs (
        .clk           (clk),
        .rst_n         (rst_n),
        .wr            (bus_wr),
        .rd            (bus_rd),
        .addr          (bus_addr),
        .wdata         (bus_wdata),
        .pins_sync     (pins_sync),
        .status        (status),
        .dout          (dout),
        .dir           (dir),
        .ien           (ien),
        .imask         (imask),
        .etype         (etype),
        .pol           (pol),
        .deb           (deb),
        .dual          (dual),
        .comb_en       (comb_en),
        .eoi_pulse     (eoi_pulse),
        .ien_clr_pulse (ien_clr_pulse),
        .rdata         (bus_rdata)
    );

    gpio_sc_infilter #(
        .NPINS       (NPINS),
        .SYNC_STAGES (SYNC_STAGES),
        .DEB_LEN     (DEB_LEN)
    ) u_infilt (
        .clk        (clk),
        .rst_n      (rst_n),
        .pin_in     (pin_in),
        .deb_en     (deb),
        .pins_sync  (pins_sync),
        .pins_clean (pins_clean)
    );

    gpio_sc_irqlogic #(.NPINS(NPINS)) u_irq (
        .clk           (clk),
        .rst_n         (rst_n),
        .clean         (pins_clean),
        .ien           (ien),
        .imask         (imask),
        .etype         (etype),
        .pol           (pol),
        .dual          (dual),
        .comb_en       (comb_en),
        .eoi_pulse     (eoi_pulse),
        .ien_clr_pulse (ien_clr_pulse),
        .pend          (pend),
        .status        (status),
        .irq           (irq_out)
    );

    assign pin_out = dout;
    assign pin_oe  = dir;

endmodule

// File: rtl/gpio_sc_checker.sv
// Module: property checker for the set/clear GPIO controller, bound to the
// top. Observes bus inputs, register state and the interrupt outputs.
module gpio_sc_checker
    import gpio_sc_pkg::*;
#(
    parameter int NPINS = 32
) (
    input logic              clk,
    input logic              rst_n,
    input logic              bus_wr,
    input logic [BUS_AW-1:0] bus_addr,
    input logic [BUS_DW-1:0] bus_wdata,
    input logic [NPINS-1:0]  pin_oe,
    input logic [NPINS-1:0]  ien,
    input logic [NPINS-1:0]  imask,
    input logic [NPINS-1:0]  pend,
    input logic [NPINS-1:0]  status,
    input logic              comb_en,
    input logic              irq_out
);

    // R2: a direction set write turns on every written bit
    p_dir_set_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && bus_addr == A_DIR_SET) |=>
        ((pin_oe & $past(bus_wdata[NPINS-1:0])) == $past(bus_wdata[NPINS-1:0])));

    // R2: a direction clear write turns off every written bit
    p_dir_clr_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && bus_addr == A_DIR_CLR) |=>
        ((pin_oe & $past(bus_wdata[NPINS-1:0])) == '0));

    // R9: nothing stays latched on a disabled pin
    p_pend_needs_en_r9: assert property (@(posedge clk) disable iff (!rst_n)
        ((pend & ~ien) == '0));

    // R10: a masked pin never shows in status
    p_mask_blocks_r10: assert property (@(posedge clk) disable iff (!rst_n)
        ((status & imask) == '0));

    // R11: the line stays low while the gate bit is off
    p_gate_off_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (!comb_en) |-> (!irq_out));

    // R11: the line is high only with some status bit present
    p_irq_source_r11: assert property (@(posedge clk) disable iff (!rst_n)
        irq_out |-> (status != '0));

endmodule

bind gpio_setclr_ctrl gpio_sc_checker #(.NPINS(NPINS)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .bus_wr    (bus_wr),
    .bus_addr  (bus_addr),
    .bus_wdata (bus_wdata),
    .pin_oe    (pin_oe),
    .ien       (ien),
    .imask     (imask),
    .pend      (pend),
    .status    (status),
    .comb_en   (comb_en),
    .irq_out   (irq_out)
);

// File: tb/gpio_setclr_ctrl_tb.sv
// Bench: scoreboard for the set/clear GPIO controller. Read tasks queue the
// expected word; a monitor pops and compares after the read completes.
module gpio_setclr_ctrl_tb;

    localparam logic [7:0] DOUT_S = 8'h00, DOUT_C = 8'h04;
    localparam logic [7:0] DIR_S  = 8'h10, DIR_C  = 8'h14, DIR_R = 8'h18;
    localparam logic [7:0] IEN_S  = 8'h20, IEN_C  = 8'h24;
    localparam logic [7:0] MSK_S  = 8'h30, MSK_C  = 8'h34;
    localparam logic [7:0] TYP_S  = 8'h40, TYP_C  = 8'h44;
    localparam logic [7:0] POL_S  = 8'h50, POL_C  = 8'h54;
    localparam logic [7:0] DEB_S  = 8'h60, DEB_C  = 8'h64;
    localparam logic [7:0] STAT   = 8'h70, EOI    = 8'h78, PINS = 8'h80;
    localparam logic [7:0] COMB   = 8'hA0;
    localparam logic [7:0] DUA_S  = 8'hB0, DUA_C  = 8'hB4, DUA_R = 8'hB8;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_wr = 1'b0;
    logic        bus_rd = 1'b0;
    logic [7:0]  bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic [31:0] pin_in = '0;
    logic [31:0] pin_out;
    logic [31:0] pin_oe;
    logic        irq_out;

    int n_cmp = 0;
    int n_bad = 0;
    logic [31:0] exp_q [$];
    string       tag_q [$];

    always #2 clk = ~clk;

    gpio_setclr_ctrl u_dut (
        .clk       (clk),
        .rst_n     (rst_n),
        .bus_wr    (bus_wr),
        .bus_rd    (bus_rd),
        .bus_addr  (bus_addr),
        .bus_wdata (bus_wdata),
        .bus_rdata (bus_rdata),
        .pin_in    (pin_in),
        .pin_out   (pin_out),
        .pin_oe    (pin_oe),
        .irq_out   (irq_out)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [7:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic rd(input logic [7:0] a, input logic [31:0] e, input string tag);
        @(negedge clk);
        bus_rd = 1'b1; bus_addr = a;
        exp_q.push_back(e);
        tag_q.push_back(tag);
        @(negedge clk);
        bus_rd = 1'b0;
    endtask

    task automatic setpin(input logic [31:0] v);
        @(negedge clk);
        pin_in = v;
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    // monitor: compare read data one clock after the sampling edge
    initial begin
        forever begin
            @(posedge clk);
            if (bus_rd) begin
                @(negedge clk);
                chk(tag_q.pop_front(), bus_rdata, exp_q.pop_front());
            end
        end
    end

    // watchdog
    initial begin
        #400000;
        n_cmp++;
        n_bad++;
        $display("FAIL watchdog actual=running expected=done");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        idle(4);
        rst_n = 1'b1;
        idle(1);

        // R1 reset state
        chk("R1 pin_oe", pin_oe, 32'h0);
        chk("R1 pin_out", pin_out, 32'h0);
        chk("R1 irq", {31'b0, irq_out}, 32'h0);
        rd(DIR_R, 32'h0, "R1 dir");
        rd(STAT, 32'h0, "R1 status");
        rd(COMB, 32'h0, "R1 comb");
        rd(DUA_R, 32'h0, "R1 dual");

        // R2 set/clear for data and direction
        wr(DOUT_S, 32'hF0F0_00FF);
        wr(DIR_S, 32'h0000_FFFF);
        chk("R2 dout set", pin_out, 32'hF0F0_00FF);
        chk("R2 dir set", pin_oe, 32'h0000_FFFF);
        wr(DOUT_C, 32'h0000_00F0);
        chk("R2 dout clr", pin_out, 32'hF0F0_000F);
        wr(DIR_C, 32'h0000_00FF);
        chk("R2 dir clr", pin_oe, 32'h0000_FF00);
        wr(DIR_S, 32'h0);
        chk("R2 zero write", pin_oe, 32'h0000_FF00);
        rd(DIR_R, 32'h0000_FF00, "R2 dir readback");

        // R3 write-only addresses read zero
        rd(DOUT_S, 32'h0, "R3 dout set");
        rd(DIR_S, 32'h0, "R3 dir set");
        rd(IEN_C, 32'h0, "R3 ien clr");
        rd(EOI, 32'h0, "R3 eoi");

        // R4 synchronised pin readback and its latency
        setpin(32'hA5A5_0000);
        rd(PINS, 32'h0, "R4 early read");
        rd(PINS, 32'hA5A5_0000, "R4 settled read");
        setpin(32'h0);
        idle(4);

        // R11 gate on
        wr(COMB, 32'h1);
        rd(COMB, 32'h1, "R11 comb readback");

        // R5 rising edge on pin 0
        wr(TYP_S, 32'h1); wr(POL_S, 32'h1); wr(IEN_S, 32'h1);
        setpin(32'h1);
        idle(2);
        chk("R5 irq before third edge", {31'b0, irq_out}, 32'h0);
        idle(1);
        chk("R5 irq at third edge", {31'b0, irq_out}, 32'h1);
        rd(STAT, 32'h1, "R5 rise status");
        wr(EOI, 32'h1);
        setpin(32'h0);
        idle(4);
        rd(STAT, 32'h0, "R5 fall ignored");
        // R5 falling edge on pin 1
        wr(TYP_S, 32'h2); wr(POL_C, 32'h2); wr(IEN_S, 32'h2);
        setpin(32'h2);
        idle(4);
        rd(STAT, 32'h0, "R5 rise ignored");
        setpin(32'h0);
        idle(4);
        rd(STAT, 32'h2, "R5 fall latched");
        wr(EOI, 32'h2);

        // R6 dual edge on pin 2
        wr(DUA_S, 32'h4);
        rd(DUA_R, 32'h4, "R6 dual readback");
        wr(IEN_S, 32'h4);
        rd(STAT, 32'h0, "R6 no event yet");
        setpin(32'h4);
        idle(4);
        rd(STAT, 32'h4, "R6 rise latched");
        wr(EOI, 32'h4);
        setpin(32'h0);
        idle(4);
        rd(STAT, 32'h4, "R6 fall latched");
        wr(EOI, 32'h4);
        wr(DUA_C, 32'h4);
        rd(STAT, 32'h4, "R6 back to level low");
        wr(IEN_C, 32'h4);
        rd(STAT, 32'h0, "R6 disabled");

        // R7 level high on pin 3
        wr(TYP_C, 32'h8); wr(POL_S, 32'h8); wr(IEN_S, 32'h8);
        rd(STAT, 32'h0, "R7 inactive");
        setpin(32'h8);
        idle(2);
        chk("R7 irq at second edge", {31'b0, irq_out}, 32'h1);
        wr(EOI, 32'h8);
        rd(STAT, 32'h8, "R7 eoi no effect");
        setpin(32'h0);
        idle(2);
        chk("R7 irq follows level", {31'b0, irq_out}, 32'h0);

        // R8 eoi clears only the written pin
        setpin(32'h1);
        idle(4);
        setpin(32'h3);
        idle(4);
        setpin(32'h1);
        idle(4);
        rd(STAT, 32'h3, "R8 two pending");
        wr(EOI, 32'h1);
        rd(STAT, 32'h2, "R8 one cleared");
        wr(EOI, 32'h2);
        rd(STAT, 32'h0, "R8 all cleared");
        setpin(32'h0);
        idle(4);

        // R9 disabled pin discards; enable clear drops latch
        wr(TYP_S, 32'h10); wr(POL_S, 32'h10);
        setpin(32'h10);
        idle(4);
        wr(IEN_S, 32'h10);
        rd(STAT, 32'h0, "R9 discarded");
        setpin(32'h0);
        idle(4);
        setpin(32'h10);
        idle(4);
        rd(STAT, 32'h10, "R9 latched when enabled");
        wr(IEN_C, 32'h10);
        wr(IEN_S, 32'h10);
        rd(STAT, 32'h0, "R9 cleared by disable");

        // R10 mask hides but keeps
        setpin(32'h0);
        idle(4);
        setpin(32'h10);
        idle(4);
        rd(STAT, 32'h10, "R10 pending");
        wr(MSK_S, 32'h10);
        rd(STAT, 32'h0, "R10 masked status");
        chk("R10 masked irq", {31'b0, irq_out}, 32'h0);
        wr(MSK_C, 32'h10);
        rd(STAT, 32'h10, "R10 unmasked status");
        chk("R10 unmasked irq", {31'b0, irq_out}, 32'h1);

        // R11 combined gate
        wr(COMB, 32'h0);
        chk("R11 gated off", {31'b0, irq_out}, 32'h0);
        rd(STAT, 32'h10, "R11 status kept");
        wr(COMB, 32'h1);
        chk("R11 gated on", {31'b0, irq_out}, 32'h1);
        wr(EOI, 32'h10);
        chk("R11 cleared", {31'b0, irq_out}, 32'h0);

        // R12 debounce on pin 5
        wr(TYP_S, 32'h20); wr(POL_S, 32'h20); wr(DEB_S, 32'h20); wr(IEN_S, 32'h20);
        setpin(32'h30);
        idle(3);
        pin_in = 32'h10;
        idle(8);
        rd(STAT, 32'h0, "R12 short pulse rejected");
        setpin(32'h30);
        idle(6);
        chk("R12 irq before accept", {31'b0, irq_out}, 32'h0);
        idle(1);
        chk("R12 irq after accept", {31'b0, irq_out}, 32'h1);
        rd(STAT, 32'h20, "R12 status");
        rd(PINS, 32'h30, "R12 pins");
        wr(EOI, 32'h20);
        wr(DEB_C, 32'h20);
        chk("R12 irq cleared", {31'b0, irq_out}, 32'h0);

        idle(3);
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

endmodule